// File: doc/BRIEF.md
# I2C Bus Transaction Monitor

This block watches the clock and data lines of a two-wire I2C bus without ever driving them. It runs on a fast system clock and passes both lines through two-flop synchronisers. It then detects edges and finds the bus conditions: START, repeated START and STOP. From the bits in between it assembles address and data bytes and reads each acknowledge slot.

Every decoded item leaves the block as a one-cycle event. The event carries a type code, the byte value and the current target address, with a flag that tells 7-bit and 10-bit addresses apart. A STOP event also carries two measurements taken since the opening START: the number of bus bits seen and the number of system cycles elapsed. A bitrate can be derived from these as bits divided by cycles times the clock period.

A bit's SDA level is sampled when SCL rises. The bit is only accepted when SCL falls again with no START or STOP in between. As a result, the SCL rise that comes before a repeated START or a STOP is never taken as a data bit.

Top module: `i2c_txn_monitor`

## Requirements
- R1: SDA falling while SCL is high is a START. It is reported as type 0 when no transfer is open, and as type 1 (repeated START) when an earlier START has had no STOP after it.
- R2: Before the first START, and after a STOP until the next START, bus activity produces no event, including STOP patterns and SCL pulses.
- R3: A bit's SDA level is sampled at SCL rise and accepted at the following SCL fall. Bits are assembled most significant first, and the eighth bit completes a byte event whose byte field holds the value.
- R4: The ninth accepted bit of each byte is the acknowledge slot. SDA low gives event type 3 (ACK) and SDA high gives type 4 (NACK).
- R5: A first address byte not of the form 11110xxx holds a 7-bit address in bits 7:1, reported with the 10-bit flag low. Bit 0 selects the direction: 1 gives type 6 (address read) and 0 gives type 5 (address write).
- R6: A first address byte of the form 11110xxx opens a 10-bit address spanning two bytes. Address bits 9:8 come from bits 2:1 of the first byte and bits 7:0 from the second byte. Both bytes report an address event with the 10-bit flag high, and the direction comes from bit 0 of the first byte.
- R7: Once all address bytes have been acknowledged, every further byte is data. It is reported as type 8 (data read) or type 7 (data write) according to the stored direction, with no limit on the number of bytes.
- R8: A START or repeated START clears the address, the partial byte and the remaining address-byte count, so the next byte is decoded as a first address byte.
- R9: The STOP event (type 2) carries the number of bits accepted since the opening START, and the cycle count (STOP detect cycle − START detect cycle + 1). Every other event carries zero in both fields. A repeated START does not restart either measurement.
- R10: A START or STOP that arrives after 1 to 7 bits of a byte drops the partial byte. A truncation event (type 9) is raised in that cycle, and the condition's own event follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| evt_valid | output | 1 | One-cycle strobe marking an event |
| evt_type | output | 4 | Event type code (0 to 9, see requirements) |
| evt_byte | output | 8 | Byte value on address and data events |
| evt_addr | output | 10 | Target address on address and data events |
| evt_addr10 | output | 1 | High when the address is 10 bits wide |
| evt_bits | output | BITS_W (16) | Bits accepted in the transfer, on STOP only |
| evt_cycles | output | CYC_W (32) | System cycles from START to STOP, on STOP only |

## Verification
The bench builds the monitor with its default widths: a 16-bit bit counter and a 32-bit cycle counter. With these widths, the exact cycle count of every transfer can be compared against times the bench records itself when it moves SDA. Each SCL phase lasts several system cycles, so the synchroniser delay cancels out of START-to-STOP differences. This lets the bench cover 7-bit and 10-bit addressing, repeated STARTs, and bytes cut short by either condition.

// File: rtl/i2c_txn_monitor.sv
module i2c_txn_monitor #(
  parameter int BITS_W = 16,
  parameter int CYC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              evt_valid,
  output logic [3:0]        evt_type,
  output logic [7:0]        evt_byte,
  output logic [9:0]        evt_addr,
  output logic              evt_addr10,
  output logic [BITS_W-1:0] evt_bits,
  output logic [CYC_W-1:0]  evt_cycles
);
  localparam logic [3:0] T_START = 4'd0, T_RSTART = 4'd1, T_STOP = 4'd2,
                         T_ACK = 4'd3, T_NACK = 4'd4, T_AWR = 4'd5, T_ARD = 4'd6,
                         T_DWR = 4'd7, T_DRD = 4'd8, T_TRUNC = 4'd9;
  localparam logic [1:0] REM_FIRST = 2'd3;

  logic [1:0] scl_s, sda_s;
  logic       scl_q, sda_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_s <= 2'b11; sda_s <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i}; sda_s <= {sda_s[0], sda_i};
      scl_q <= scl_s[1];          sda_q <= sda_s[1];
    end
  end

  wire scl     = scl_s[1];
  wire sda     = sda_s[1];
  wire scl_r   = scl & ~scl_q;
  wire scl_f   = ~scl & scl_q;
  wire start_c = scl & scl_q & sda_q & ~sda;
  wire stop_c  = scl & scl_q & ~sda_q & sda;

  logic              active, bit_pend, bit_val, is_rd, addr10;
  logic [3:0]        bit_cnt;
  logic [6:0]        shreg;
  logic [1:0]        rem;
  logic [9:0]        addr;
  logic [BITS_W-1:0] nbits;
  logic [CYC_W-1:0]  ncyc;
  logic              pend_v;
  logic [3:0]        pend_t;
  logic [BITS_W-1:0] pend_bits;
  logic [CYC_W-1:0]  pend_cyc;

  wire [7:0] full    = {shreg, bit_val};
  wire       partial = (bit_cnt != 4'd0) && (bit_cnt != 4'd8);
  wire       commit  = active & scl_f & bit_pend;

  logic [9:0] addr_nx;
  logic       a10_nx, rd_nx;
  logic [1:0] rem_nx;
  logic [3:0] byte_t;
  always_comb begin
    addr_nx = addr; a10_nx = addr10; rd_nx = is_rd; rem_nx = rem;
    if (rem == REM_FIRST) begin
      rd_nx = full[0];
      if (full[7:3] == 5'b11110) begin
        addr_nx = {full[2:1], 8'h00}; a10_nx = 1'b1; rem_nx = 2'd2;
      end else begin
        addr_nx = {3'b000, full[7:1]}; a10_nx = 1'b0; rem_nx = 2'd1;
      end
    end else if (rem != 2'd0) begin
      addr_nx[7:0] = full;
    end
    if (rem != 2'd0) byte_t = rd_nx ? T_ARD : T_AWR;
    else             byte_t = is_rd ? T_DRD : T_DWR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; bit_pend <= 1'b0; bit_val <= 1'b0; is_rd <= 1'b0; addr10 <= 1'b0;
      bit_cnt <= '0; shreg <= '0; rem <= REM_FIRST; addr <= '0; nbits <= '0; ncyc <= '0;
      pend_v <= 1'b0; pend_t <= '0; pend_bits <= '0; pend_cyc <= '0;
      evt_valid <= 1'b0; evt_type <= '0; evt_byte <= '0; evt_addr <= '0;
      evt_addr10 <= 1'b0; evt_bits <= '0; evt_cycles <= '0;
    end else begin
      evt_valid <= 1'b0; evt_bits <= '0; evt_cycles <= '0; pend_v <= 1'b0;
      if (active) ncyc <= ncyc + 1'b1;
      if (pend_v) begin
        evt_valid <= 1'b1; evt_type <= pend_t; evt_bits <= pend_bits; evt_cycles <= pend_cyc;
      end
      if (start_c) begin
        evt_valid <= 1'b1;
        if (active && partial) begin
          evt_type <= T_TRUNC; pend_v <= 1'b1; pend_t <= T_RSTART;
          pend_bits <= '0; pend_cyc <= '0;
        end else begin
          evt_type <= active ? T_RSTART : T_START;
        end
        if (!active) begin nbits <= '0; ncyc <= 1; end
        active <= 1'b1; bit_pend <= 1'b0; bit_cnt <= '0; rem <= REM_FIRST;
        addr <= '0; addr10 <= 1'b0; is_rd <= 1'b0;
      end else if (stop_c && active) begin
        evt_valid <= 1'b1;
        if (partial) begin
          evt_type <= T_TRUNC; pend_v <= 1'b1; pend_t <= T_STOP;
          pend_bits <= nbits; pend_cyc <= ncyc + 1'b1;
        end else begin
          evt_type <= T_STOP; evt_bits <= nbits; evt_cycles <= ncyc + 1'b1;
        end
        active <= 1'b0; bit_pend <= 1'b0; bit_cnt <= '0;
      end else if (active && scl_r) begin
        bit_pend <= 1'b1; bit_val <= sda;
      end else if (commit) begin
        bit_pend <= 1'b0; nbits <= nbits + 1'b1;
        if (bit_cnt == 4'd8) begin
          evt_valid <= 1'b1; evt_type <= bit_val ? T_NACK : T_ACK;
          bit_cnt <= '0;
          if (rem != 2'd0) rem <= rem - 2'd1;
        end else if (bit_cnt == 4'd7) begin
          evt_valid <= 1'b1; evt_type <= byte_t; evt_byte <= full;
          evt_addr <= addr_nx; evt_addr10 <= a10_nx;
          addr <= addr_nx; addr10 <= a10_nx; is_rd <= rd_nx; rem <= rem_nx;
          bit_cnt <= 4'd8;
        end else begin
          shreg <= {shreg[5:0], bit_val}; bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !pend_v && !start_c) |=> !evt_valid);
  p_start_fresh_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_type == T_START) |-> (active && !$past(active)));
  p_bitcnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= 4'd8);
  p_meas_stop_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_type != T_STOP) |-> (evt_bits == '0 && evt_cycles == '0));
  p_trunc_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_type == T_TRUNC) |=>
      (evt_valid && (evt_type == T_RSTART || evt_type == T_STOP)));
endmodule

// File: tb/i2c_txn_monitor_tb_top.sv
module i2c_txn_monitor_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda = 1'b1;
  always #5 clk = ~clk;

  logic        evt_valid, evt_addr10;
  logic [3:0]  evt_type;
  logic [7:0]  evt_byte;
  logic [9:0]  evt_addr;
  logic [15:0] evt_bits;
  logic [31:0] evt_cycles;

  i2c_txn_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .evt_valid(evt_valid), .evt_type(evt_type), .evt_byte(evt_byte),
    .evt_addr(evt_addr), .evt_addr10(evt_addr10),
    .evt_bits(evt_bits), .evt_cycles(evt_cycles));

  typedef struct packed {
    logic [3:0] t; logic [7:0] b; logic [9:0] a; logic a10;
    logic [15:0] bits; logic [31:0] cyc;
  } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0, cyc_n = 0;
  always @(posedge clk) cyc_n++;

  bit m_act = 0, m_rd = 0, m_a10 = 0;
  int m_bits = 0, m_t0 = 0, m_cnt = 0;
  logic [1:0] m_rem = 2'd3;
  logic [9:0] m_addr = '0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string req_of(logic [3:0] t, logic a10);
    case (t)
      4'd0, 4'd1: return "R1";
      4'd2:       return "R9";
      4'd3, 4'd4: return "R4";
      4'd5, 4'd6: return a10 ? "R6" : "R5";
      4'd7, 4'd8: return "R7";
      default:    return "R10";
    endcase
  endfunction

  function automatic void push(logic [3:0] t, logic [7:0] b, logic [9:0] a, logic a10,
                               logic [15:0] bits, logic [31:0] cyc);
    q.push_back('{t: t, b: b, a: a, a10: a10, bits: bits, cyc: cyc});
  endfunction

  always @(negedge clk) begin
    if (rst_n && evt_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R2", "unexpected event type", evt_type, 15);
      end else begin
        exp_t e;
        string r;
        e = q.pop_front();
        r = req_of(e.t, e.a10);
        chk(evt_type == e.t, r, "event type", evt_type, e.t);
        if (e.t >= 4'd5 && e.t <= 4'd8) begin
          chk(evt_byte == e.b, "R3", "byte value", evt_byte, e.b);
          chk(evt_addr == e.a, r, "address", evt_addr, e.a);
          chk(evt_addr10 == e.a10, r, "10-bit flag", evt_addr10, e.a10);
        end
        chk(evt_bits == e.bits, "R9", "bit count", evt_bits, e.bits);
        chk(evt_cycles == e.cyc, "R9", "cycle count", evt_cycles, e.cyc);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clk_bit(bit b);
    sda = b; tick(3);
    scl = 1'b1; tick(4);
    scl = 1'b0; if (m_act) m_bits++; tick(3);
  endtask

  task automatic do_start();
    if (scl == 1'b0) begin sda = 1'b1; tick(3); scl = 1'b1; tick(3); end
    if (m_act && m_cnt != 0 && m_cnt != 8) push(4'd9, 0, 0, 0, 0, 0);
    push(m_act ? 4'd1 : 4'd0, 0, 0, 0, 0, 0);
    if (!m_act) begin m_bits = 0; m_t0 = cyc_n; end
    m_act = 1; m_cnt = 0; m_rem = 2'd3; m_addr = '0; m_a10 = 0; m_rd = 0;
    sda = 1'b0; tick(4);
    scl = 1'b0; tick(3);
  endtask

  task automatic do_stop();
    sda = 1'b0; tick(3);
    scl = 1'b1; tick(4);
    if (m_act) begin
      if (m_cnt != 0 && m_cnt != 8) push(4'd9, 0, 0, 0, 0, 0);
      push(4'd2, 0, 0, 0, 16'(m_bits), 32'(cyc_n - m_t0 + 1));
    end
    m_act = 0; m_cnt = 0;
    sda = 1'b1; tick(5);
  endtask

  task automatic send_byte(logic [7:0] b);
    logic [3:0] t;
    if (m_act) begin
      if (m_rem != 2'd0) begin
        if (m_rem == 2'd3) begin
          m_rd = b[0];
          if (b[7:3] == 5'b11110) begin m_addr = {b[2:1], 8'h00}; m_a10 = 1; m_rem = 2'd2; end
          else begin m_addr = {3'b000, b[7:1]}; m_a10 = 0; m_rem = 2'd1; end
        end else begin
          m_addr[7:0] = b;
        end
        t = m_rd ? 4'd6 : 4'd5;
      end else begin
        t = m_rd ? 4'd8 : 4'd7;
      end
      push(t, b, m_addr, m_a10, 0, 0);
    end
    for (int i = 7; i >= 0; i--) clk_bit(b[i]);
    if (m_act) m_cnt = 8;
  endtask

  task automatic send_ack(bit nack);
    if (m_act) push(nack ? 4'd4 : 4'd3, 0, 0, 0, 0, 0);
    clk_bit(nack);
    if (m_act) begin m_cnt = 0; if (m_rem != 2'd0) m_rem = m_rem - 2'd1; end
  endtask

  task automatic send_partial(logic [7:0] b, int k);
    for (int i = 7; i > 7 - k; i--) clk_bit(b[i]);
    if (m_act) m_cnt = k;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick(4); rst_n = 1'b1; tick(2);
    chk(evt_valid == 1'b0, "R2", "valid after reset", evt_valid, 0);
    // R2: traffic before any START is ignored
    scl = 1'b0; tick(3);
    send_byte(8'hA5); send_ack(1'b0); do_stop();
    // 7-bit write with data bytes (R3 R4 R5 R7 R9)
    do_start(); send_byte(8'hA0); send_ack(0);
    send_byte(8'h3C); send_ack(0); send_byte(8'hFF); send_ack(1); do_stop();
    // 7-bit read
    do_start(); send_byte(8'hA3); send_ack(0); send_byte(8'h81); send_ack(1); do_stop();
    // 10-bit write then repeated START and 10-bit read (R6, R8: fresh address phase)
    do_start(); send_byte(8'hF2); send_ack(0); send_byte(8'h5A); send_ack(0);
    send_byte(8'h11); send_ack(0);
    do_start(); send_byte(8'hF3); send_ack(0); send_byte(8'h5A); send_ack(0);
    send_byte(8'h22); send_ack(1); do_stop();
    // R10: partial byte cut by repeated START, then by STOP
    do_start(); send_byte(8'h40); send_ack(0); send_partial(8'hA0, 3);
    do_start(); send_byte(8'h41); send_ack(0); send_partial(8'hC0, 2);
    do_stop();
    // R2: traffic after STOP is ignored
    scl = 1'b0; tick(3); send_byte(8'h0F); send_ack(0);
    scl = 1'b1; sda = 1'b1; tick(20);
    chk(q.size() == 0, "R1", "events left unmatched", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule